// File: doc/BRIEF.md
# Pipeline Control Bundle Carrier

This block produces the control word of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It works from the opcode held in the fetch/decode register. The whole word is decoded once, in the decode stage, and split into three groups. The execute group selects the destination register, the ALU mode and the operand source. The memory group carries the branch, read and write strobes. The write-back group chooses the result source and the register write enable.

The groups then travel down the three pipeline registers that follow decode. The first of these registers holds all three groups. The second holds only the memory and write-back groups, and the third holds only the write-back group. Each stage reads its own group from the register in front of it and passes on only what later stages still need.

A valid bit travels with every bundle, and every stage output is forced to zero when that bit is clear. A bubble request places an empty, invalid bundle into the first register, so the instruction held in decode starts no memory write and no register write. Instructions further down the pipeline are not affected. A synchronous reset empties all three registers.

Top module: `pipe_ctrl_carrier`

## Requirements
- R1: While `rst` is high at a rising edge, all three pipeline registers are cleared at that edge, so every output is 0 afterwards. Reset takes priority over `id_valid` and `bubble`.
- R2: A valid opcode 0x00 (register-register ALU) gives the execute outputs dst_rd=1, alu_mode=2'b10 (take the function field) and src_imm=0. Its memory outputs are branch=0, read=0, write=0, and its write-back outputs are from_mem=0, reg_we=1.
- R3: A valid opcode 0x23 (load) gives dst_rd=0, alu_mode=2'b00 (add), src_imm=1. Its memory outputs are read=1, write=0, branch=0, and its write-back outputs are from_mem=1, reg_we=1.
- R4: A valid opcode 0x2B (store) gives dst_rd=0, alu_mode=2'b00, src_imm=1. Its memory outputs are write=1, read=0, branch=0, and its write-back outputs are from_mem=0, reg_we=0.
- R5: A valid opcode 0x04 (branch on equal) gives dst_rd=0, alu_mode=2'b01 (subtract), src_imm=0. Its memory outputs are branch=1, read=0, write=0, and both write-back controls are 0.
- R6: A valid opcode 0x08 (add immediate) gives dst_rd=0, alu_mode=2'b00, src_imm=1. All memory controls are 0, and its write-back outputs are from_mem=0, reg_we=1.
- R7: A valid opcode with any other value travels with its valid bit set in every stage, but all of its control outputs are 0.
- R8: An opcode sampled at rising edge k shows on the execute outputs after edge k. It shows on the memory outputs after edge k+1 and on the write-back outputs after edge k+2. The valid bit of each stage output follows the same timing.
- R9: A new opcode can be accepted at every edge. Back-to-back instructions appear in issue order in every stage, and no instruction's controls mix with a neighbour's.
- R10: When `bubble` is high at an edge, the execute stage is empty after that edge (valid 0, all controls 0). The same empty slot then passes through memory and write-back with no write strobe, whatever `id_valid` and `id_opcode` were.
- R11: When `id_valid` is low, the slot created at that edge is invalid, and every control output is 0 in each stage the slot passes through, whatever the opcode.
- R12: A bubble changes only the slot entering execute. Instructions already in the memory and write-back stages complete with their own controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | The decode slot holds a real instruction |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| bubble | input | 1 | Load an empty bundle into the execute register |
| ex_valid | output | 1 | Execute stage holds a valid instruction |
| ex_dst_rd | output | 1 | Destination is the third register field |
| ex_alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| ex_src_imm | output | 1 | Second ALU operand is the extended immediate |
| mem_valid | output | 1 | Memory stage holds a valid instruction |
| mem_branch | output | 1 | Conditional branch in memory stage |
| mem_read | output | 1 | Data memory read strobe |
| mem_write | output | 1 | Data memory write strobe |
| wb_valid | output | 1 | Write-back stage holds a valid instruction |
| wb_from_mem | output | 1 | Write-back data comes from memory |
| wb_reg_we | output | 1 | Register file write enable |

## Verification
A wrong decode entry shows on the execute outputs one edge after the opcode is sampled. Its memory and write-back parts show one and two edges later. A group that is dropped or shifted between registers appears as a memory or write-back value that disagrees with the instruction seen in execute a cycle earlier. A missing valid gate or a missing bubble clear appears as a write strobe on a slot that should be empty, at the latest two edges after the event. A reset that fails to clear a register shows on that stage's outputs at the first check after reset.

// File: rtl/pipe_ctrl_pkg.sv
`timescale 1ns/1ps
package pipe_ctrl_pkg;

    localparam int OPC_W = 6;
    typedef logic [OPC_W-1:0] opc_t;

    // Opcode values decoded by the carrier
    localparam opc_t OPC_REG   = 6'h00;
    localparam opc_t OPC_LOAD  = 6'h23;
    localparam opc_t OPC_STORE = 6'h2B;
    localparam opc_t OPC_BEQ   = 6'h04;
    localparam opc_t OPC_ADDI  = 6'h08;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10,
        ALU_RSV   = 2'b11
    } alu_mode_e;

    // Group consumed in execute
    typedef struct packed {
        logic      dst_rd;
        alu_mode_e alu_mode;
        logic      src_imm;
    } ex_grp_t;

    // Group consumed in memory access
    typedef struct packed {
        logic is_branch;
        logic load;
        logic store;
    } mem_grp_t;

    // Group consumed in write-back
    typedef struct packed {
        logic from_mem;
        logic reg_we;
    } wb_grp_t;

    // Contents of each pipeline register, widest first
    typedef struct packed {
        wb_grp_t  wb;
        mem_grp_t m;
        ex_grp_t  ex;
    } idex_t;

    typedef struct packed {
        wb_grp_t  wb;
        mem_grp_t m;
    } exmem_t;

    localparam int IDEX_W  = $bits(idex_t);
    localparam int EXMEM_W = $bits(exmem_t);
    localparam int MEMWB_W = $bits(wb_grp_t);

    localparam ex_grp_t  EX_NONE  = '{dst_rd: 1'b0, alu_mode: ALU_ADD, src_imm: 1'b0};
    localparam mem_grp_t MEM_NONE = '{is_branch: 1'b0, load: 1'b0, store: 1'b0};
    localparam wb_grp_t  WB_NONE  = '{from_mem: 1'b0, reg_we: 1'b0};

    // Clear a group when its slot is empty
    function automatic ex_grp_t gate_ex(input ex_grp_t g, input logic v);
        return v ? g : EX_NONE;
    endfunction

    function automatic mem_grp_t gate_mem(input mem_grp_t g, input logic v);
        return v ? g : MEM_NONE;
    endfunction

    function automatic wb_grp_t gate_wb(input wb_grp_t g, input logic v);
        return v ? g : WB_NONE;
    endfunction

endpackage

// File: rtl/ctrl_decoder.sv
`timescale 1ns/1ps
module ctrl_decoder
    import pipe_ctrl_pkg::*;
(
    input  opc_t  opcode,
    output idex_t bundle
);

    // R2..R7: one full control word per opcode, built in decode
    always_comb begin
        bundle.ex = EX_NONE;
        bundle.m  = MEM_NONE;
        bundle.wb = WB_NONE;
        unique case (opcode)
            OPC_REG: begin
                bundle.ex.dst_rd   = 1'b1;
                bundle.ex.alu_mode = ALU_FUNCT;
                bundle.wb.reg_we   = 1'b1;
            end
            OPC_LOAD: begin
                bundle.ex.src_imm  = 1'b1;
                bundle.m.load      = 1'b1;
                bundle.wb.from_mem = 1'b1;
                bundle.wb.reg_we   = 1'b1;
            end
            OPC_STORE: begin
                bundle.ex.src_imm  = 1'b1;
                bundle.m.store     = 1'b1;
            end
            OPC_BEQ: begin
                bundle.ex.alu_mode = ALU_SUB;
                bundle.m.is_branch = 1'b1;
            end
            OPC_ADDI: begin
                bundle.ex.src_imm  = 1'b1;
                bundle.wb.reg_we   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctrl_stage_reg.sv
`timescale 1ns/1ps
module ctrl_stage_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_empty,
    input  logic         in_valid,
    input  logic [W-1:0] in_bits,
    output logic         out_valid,
    output logic [W-1:0] out_bits
);

    // R1 reset and R10 bubble both leave an empty slot
    always_ff @(posedge clk) begin
        if (rst || load_empty) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= in_valid;
            out_bits  <= in_bits;
        end
    end

endmodule

// File: rtl/pipe_ctrl_carrier.sv
`timescale 1ns/1ps
module pipe_ctrl_carrier
    import pipe_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [OPC_W-1:0] id_opcode,
    input  logic             bubble,
    output logic             ex_valid,
    output logic             ex_dst_rd,
    output logic [1:0]       ex_alu_mode,
    output logic             ex_src_imm,
    output logic             mem_valid,
    output logic             mem_branch,
    output logic             mem_read,
    output logic             mem_write,
    output logic             wb_valid,
    output logic             wb_from_mem,
    output logic             wb_reg_we
);

    idex_t dec_bundle;

    logic               idex_v;
    logic [IDEX_W-1:0]  idex_raw;
    idex_t              idex_q;
    logic               exmem_v;
    logic [EXMEM_W-1:0] exmem_raw;
    exmem_t             exmem_q;
    exmem_t             exmem_d;
    logic               memwb_v;
    logic [MEMWB_W-1:0] memwb_raw;
    wb_grp_t            memwb_q;

    ex_grp_t  ex_out;
    mem_grp_t mem_out;
    wb_grp_t  wb_out;

    ctrl_decoder u_dec (
        .opcode (id_opcode),
        .bundle (dec_bundle)
    );

    // Decode/execute register: all three groups (R8)
    ctrl_stage_reg #(.W(IDEX_W)) u_idex (
        .clk        (clk),
        .rst        (rst),
        .load_empty (bubble),
        .in_valid   (id_valid),
        .in_bits    (dec_bundle),
        .out_valid  (idex_v),
        .out_bits   (idex_raw)
    );
    assign idex_q = idex_t'(idex_raw);

    // Execute/memory register: execute group dropped
    assign exmem_d.wb = idex_q.wb;
    assign exmem_d.m  = idex_q.m;

    ctrl_stage_reg #(.W(EXMEM_W)) u_exmem (
        .clk        (clk),
        .rst        (rst),
        .load_empty (1'b0),
        .in_valid   (idex_v),
        .in_bits    (exmem_d),
        .out_valid  (exmem_v),
        .out_bits   (exmem_raw)
    );
    assign exmem_q = exmem_t'(exmem_raw);

    // Memory/write-back register: only write-back group remains
    ctrl_stage_reg #(.W(MEMWB_W)) u_memwb (
        .clk        (clk),
        .rst        (rst),
        .load_empty (1'b0),
        .in_valid   (exmem_v),
        .in_bits    (exmem_q.wb),
        .out_valid  (memwb_v),
        .out_bits   (memwb_raw)
    );
    assign memwb_q = wb_grp_t'(memwb_raw);

    // R11: every stage output gated by its own valid bit
    assign ex_out  = gate_ex(idex_q.ex, idex_v);
    assign mem_out = gate_mem(exmem_q.m, exmem_v);
    assign wb_out  = gate_wb(memwb_q, memwb_v);

    assign ex_valid    = idex_v;
    assign ex_dst_rd   = ex_out.dst_rd;
    assign ex_alu_mode = ex_out.alu_mode;
    assign ex_src_imm  = ex_out.src_imm;
    assign mem_valid   = exmem_v;
    assign mem_branch  = mem_out.is_branch;
    assign mem_read    = mem_out.load;
    assign mem_write   = mem_out.store;
    assign wb_valid    = memwb_v;
    assign wb_from_mem = wb_out.from_mem;
    assign wb_reg_we   = wb_out.reg_we;

endmodule

// File: rtl/pipe_ctrl_carrier_chk.sv
`timescale 1ns/1ps
module pipe_ctrl_carrier_chk (
    input logic       clk,
    input logic       rst,
    input logic       bubble,
    input logic       ex_valid,
    input logic       ex_dst_rd,
    input logic [1:0] ex_alu_mode,
    input logic       ex_src_imm,
    input logic       mem_valid,
    input logic       mem_branch,
    input logic       mem_read,
    input logic       mem_write,
    input logic       wb_valid,
    input logic       wb_from_mem,
    input logic       wb_reg_we
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!ex_valid && !mem_valid && !wb_valid));

    assert_bubble_empty_R10: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (!ex_valid && !ex_dst_rd && ex_alu_mode == 2'b00 && !ex_src_imm)
                   ##1 (!mem_valid && !mem_write)
                   ##1 (!wb_valid && !wb_reg_we));

    assert_valid_chain_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mem_valid == $past(ex_valid)) && (wb_valid == $past(mem_valid)));

    assert_load_source_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wb_from_mem == $past(mem_read)));

    assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));

    assert_branch_no_access_R5: assert property (@(posedge clk) disable iff (rst)
        mem_branch |-> (!mem_read && !mem_write));

endmodule

bind pipe_ctrl_carrier pipe_ctrl_carrier_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bubble      (bubble),
    .ex_valid    (ex_valid),
    .ex_dst_rd   (ex_dst_rd),
    .ex_alu_mode (ex_alu_mode),
    .ex_src_imm  (ex_src_imm),
    .mem_valid   (mem_valid),
    .mem_branch  (mem_branch),
    .mem_read    (mem_read),
    .mem_write   (mem_write),
    .wb_valid    (wb_valid),
    .wb_from_mem (wb_from_mem),
    .wb_reg_we   (wb_reg_we)
);

// File: tb/pipe_ctrl_carrier_test.sv
`timescale 1ns/1ps
module pipe_ctrl_carrier_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [5:0] id_opcode = 6'h3F;
    logic       bubble = 1'b0;
    logic       ex_valid, ex_dst_rd, ex_src_imm;
    logic [1:0] ex_alu_mode;
    logic       mem_valid, mem_branch, mem_read, mem_write;
    logic       wb_valid, wb_from_mem, wb_reg_we;

    int n_run  = 0;
    int n_fail = 0;

    // Bench model: (valid, opcode) held in each stage
    logic       m_ex_v = 1'b0, m_mem_v = 1'b0, m_wb_v = 1'b0;
    logic [5:0] m_ex_o = '0,   m_mem_o = '0,   m_wb_o = '0;

    always #10 clk = ~clk;  // 50 MHz

    pipe_ctrl_carrier uut (
        .clk         (clk),
        .rst         (rst),
        .id_valid    (id_valid),
        .id_opcode   (id_opcode),
        .bubble      (bubble),
        .ex_valid    (ex_valid),
        .ex_dst_rd   (ex_dst_rd),
        .ex_alu_mode (ex_alu_mode),
        .ex_src_imm  (ex_src_imm),
        .mem_valid   (mem_valid),
        .mem_branch  (mem_branch),
        .mem_read    (mem_read),
        .mem_write   (mem_write),
        .wb_valid    (wb_valid),
        .wb_from_mem (wb_from_mem),
        .wb_reg_we   (wb_reg_we)
    );

    // Control table from R2..R7: {dst_rd, alu_mode[1:0], src_imm, branch, read, write, from_mem, reg_we}
    function automatic logic [8:0] ctl_of(input logic [5:0] o);
        case (o)
            6'h00:   return 9'b1_10_1_000_01 & 9'b1_11_0_111_11;
            6'h23:   return 9'b0_00_1_010_11;
            6'h2B:   return 9'b0_00_1_001_00;
            6'h04:   return 9'b0_01_0_100_00;
            6'h08:   return 9'b0_00_1_000_01;
            default: return 9'b0;
        endcase
    endfunction

    function automatic logic [11:0] expected();
        logic [8:0] ce, cm, cw;
        ce = m_ex_v  ? ctl_of(m_ex_o)  : 9'b0;
        cm = m_mem_v ? ctl_of(m_mem_o) : 9'b0;
        cw = m_wb_v  ? ctl_of(m_wb_o)  : 9'b0;
        return {m_ex_v, ce[8:5], m_mem_v, cm[4:2], m_wb_v, cw[1:0]};
    endfunction

    function automatic logic [11:0] observed();
        return {ex_valid, ex_dst_rd, ex_alu_mode, ex_src_imm,
                mem_valid, mem_branch, mem_read, mem_write,
                wb_valid, wb_from_mem, wb_reg_we};
    endfunction

    task automatic check(input string tag);
        logic [11:0] a, e;
        a = observed();
        e = expected();
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, a, e);
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next slot
    task automatic cyc(input logic v, input logic [5:0] o, input logic b, input string tag);
        @(negedge clk);
        check(tag);
        m_wb_v  = m_mem_v; m_wb_o  = m_mem_o;
        m_mem_v = m_ex_v;  m_mem_o = m_ex_o;
        m_ex_v  = b ? 1'b0 : v;
        m_ex_o  = o;
        id_valid  = v;
        id_opcode = o;
        bubble    = b;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 3; i++) cyc(1'b0, 6'h3F, 1'b0, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; id_valid = 1'b1; id_opcode = 6'h23; bubble = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; id_valid = 1'b0; id_opcode = 6'h3F;
        m_ex_v = 1'b0; m_mem_v = 1'b0; m_wb_v = 1'b0;
        cyc(1'b0, 6'h3F, 1'b0, "R1 reset state");
    endtask

    task automatic t_single(input logic [5:0] o, input string tag);
        cyc(1'b1, o, 1'b0, tag);
        cyc(1'b0, 6'h3F, 1'b0, {tag, " R8 ex"});
        cyc(1'b0, 6'h3F, 1'b0, {tag, " R8 mem"});
        cyc(1'b0, 6'h3F, 1'b0, {tag, " R8 wb"});
    endtask

    task automatic t_back_to_back();
        cyc(1'b1, 6'h00, 1'b0, "R9 seq");
        cyc(1'b1, 6'h23, 1'b0, "R9 seq");
        cyc(1'b1, 6'h2B, 1'b0, "R9 seq");
        cyc(1'b1, 6'h04, 1'b0, "R9 seq");
        cyc(1'b1, 6'h08, 1'b0, "R9 seq");
        cyc(1'b1, 6'h23, 1'b0, "R9 seq");
        drain("R9 drain");
    endtask

    task automatic t_invalid();
        cyc(1'b0, 6'h23, 1'b0, "R11 invalid");
        cyc(1'b0, 6'h2B, 1'b0, "R11 invalid");
        cyc(1'b0, 6'h00, 1'b0, "R11 invalid");
        drain("R11 drain");
    endtask

    task automatic t_bubble();
        cyc(1'b1, 6'h2B, 1'b1, "R10 bubble");
        cyc(1'b1, 6'h23, 1'b1, "R10 bubble");
        cyc(1'b1, 6'h00, 1'b1, "R10 bubble");
        drain("R10 drain");
    endtask

    task automatic t_bubble_midstream();
        cyc(1'b1, 6'h23, 1'b0, "R12 mid");
        cyc(1'b1, 6'h2B, 1'b0, "R12 mid");
        cyc(1'b1, 6'h00, 1'b1, "R12 mid");
        cyc(1'b1, 6'h08, 1'b0, "R12 mid");
        drain("R12 drain");
    endtask

    task automatic t_reset_midstream();
        cyc(1'b1, 6'h23, 1'b0, "R1 fill");
        cyc(1'b1, 6'h2B, 1'b0, "R1 fill");
        cyc(1'b1, 6'h00, 1'b0, "R1 fill");
        @(negedge clk);
        check("R1 fill");
        rst = 1'b1; id_valid = 1'b1; id_opcode = 6'h08; bubble = 1'b0;
        m_ex_v = 1'b0; m_mem_v = 1'b0; m_wb_v = 1'b0;
        @(negedge clk);
        check("R1 midstream clear");
        rst = 1'b0; id_valid = 1'b0; id_opcode = 6'h3F;
        drain("R1 after");
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single(6'h00, "R2 reg");
        t_single(6'h23, "R3 load");
        t_single(6'h2B, "R4 store");
        t_single(6'h04, "R5 branch");
        t_single(6'h08, "R6 addi");
        t_single(6'h15, "R7 unknown");
        t_single(6'h3F, "R7 unknown");
        t_back_to_back();
        t_invalid();
        t_bubble();
        t_bubble_midstream();
        t_reset_midstream();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule